// File: doc/BRIEF.md
# Specific Station Address Match Filter

This block compares the destination address of each received frame against a small set of programmable 48-bit station addresses. Each station address is kept in a pair of registers behind a 32-bit write port: a low word carrying address bits 31:0 and a high word carrying bits 47:32 in its least significant 16 bits. The receive path presents a 48-bit destination address with a one-cycle strobe. One clock later the block reports that a result is ready, whether any enabled pair matched, and the index of the pair that matched.

Each pair has an enable that follows the order of writes. Writing the low word turns matching off for that pair, and writing the high word turns it back on. Software can therefore rewrite an address while frames are arriving, and no half-updated address is ever compared. Writes are accepted at any time. When several enabled pairs hold the same address, the pair with the lowest index is reported.

Top module: `addr_match_filter`

## Requirements
- R1: After reset every pair is disabled and hit_valid, hit and hit_idx are 0. A strobe of address 0 before any write gives no hit.
- R2: hit_valid is 1 in the cycle that follows each cycle with da_valid = 1, and it is 0 otherwise. hit is never 1 while hit_valid is 0.
- R3: With wr_en = 1, wr_sel[0] = 0 selects the low word and wr_sel[0] = 1 selects the high word of the pair numbered wr_sel[2:1]. The low word stores wr_data[31:0] as address bits 31:0. The high word stores wr_data[15:0] as bits 47:32, and wr_data[31:16] is ignored. An enabled pair whose 48 bits equal da produces hit = 1 and hit_idx equal to the pair number.
- R4: Writing the low word of a pair disables matching for that pair, even when the stored address equals da.
- R5: Writing the high word of a pair enables matching for that pair.
- R6: When more than one enabled pair matches, hit_idx is the lowest matching pair number.
- R7: Writes are accepted in any cycle. A strobe in the same cycle as a write is compared against the register and enable state from before that write.
- R8: hit_idx is 0 whenever hit is 0.
- R9: An address that differs from a stored address in any single bit (bits 0, 31, 32 and 47 are tested) does not match that pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Bit 0 selects the word (0 = low, 1 = high); bits 2:1 select the pair |
| wr_data | input | 32 | Write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address of the received frame |
| hit_valid | output | 1 | Result ready, one cycle after da_valid |
| hit | output | 1 | Some enabled pair matched |
| hit_idx | output | 2 | Lowest matching pair number, 0 when there is no hit |

## Verification
The assertions assume that the write port and the address strobe carry known values once reset has been released. The checker builds its own model of the per-pair enables from the write port, so it also assumes that every write in which wr_en = 1 is a real write. The directed stimulus drives every input on the falling edge and never leaves a value undriven. Some scenarios deliberately place a strobe in the same cycle as a write, to test that the comparison uses the state from before the write.

// File: rtl/sa_filter_pkg.sv
package sa_filter_pkg;
  // Word selector carried in bit 0 of the register select
  typedef enum logic {
    WORD_LOW  = 1'b0,
    WORD_HIGH = 1'b1
  } sa_word_e;
endpackage

// File: rtl/sa_pair_reg.sv
// One station address register pair with write-order controlled enable
module sa_pair_reg #(
  parameter int LO_W = 32,
  parameter int HI_W = 16,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [LO_W-1:0]   lo_data,
  input  logic [HI_W-1:0]   hi_data,
  input  logic [ADDR_W-1:0] da,
  output logic              match
);
  logic [LO_W-1:0] lo_q;
  logic [HI_W-1:0] hi_q;
  logic            en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
      en_q <= 1'b0;
    end else if (wr_lo) begin
      lo_q <= lo_data;
      en_q <= 1'b0;
    end else if (wr_hi) begin
      hi_q <= hi_data;
      en_q <= 1'b1;
    end
  end

  assign match = en_q && (da == {hi_q, lo_q});
endmodule

// File: rtl/sa_prio_pick.sv
// Lowest-index-first selection among match requests
module sa_prio_pick #(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = i[IDX_W-1:0];
    end
  end
endmodule

// File: rtl/addr_match_filter.sv
module addr_match_filter #(
  parameter int NUM_PAIRS = 4,
  parameter int ADDR_W    = 48,
  parameter int DATA_W    = 32,
  localparam int HI_W  = ADDR_W - DATA_W,
  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int SEL_W = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              da_valid,
  input  logic [ADDR_W-1:0] da,
  output logic              hit_valid,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  import sa_filter_pkg::*;

  logic [NUM_PAIRS-1:0] match_vec;
  logic                 any_match;
  logic [IDX_W-1:0]     pick_idx;
  sa_word_e             word_sel;

  assign word_sel = sa_word_e'(wr_sel[0]);

  // Upper write bits have no destination in the high word
  wire unused_upper = ^wr_data[DATA_W-1:HI_W];

  for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
    logic pair_sel;
    assign pair_sel = wr_en && (wr_sel[SEL_W-1:1] == IDX_W'(k));

    sa_pair_reg #(
      .LO_W (DATA_W),
      .HI_W (HI_W)
    ) u_pair (
      .clk     (clk),
      .rst     (rst),
      .wr_lo   (pair_sel && (word_sel == WORD_LOW)),
      .wr_hi   (pair_sel && (word_sel == WORD_HIGH)),
      .lo_data (wr_data),
      .hi_data (wr_data[HI_W-1:0]),
      .da      (da),
      .match   (match_vec[k])
    );
  end

  sa_prio_pick #(.N(NUM_PAIRS)) u_pick (
    .req (match_vec),
    .any (any_match),
    .idx (pick_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_valid <= 1'b0;
      hit       <= 1'b0;
      hit_idx   <= '0;
    end else begin
      hit_valid <= da_valid;
      hit       <= da_valid && any_match;
      hit_idx   <= (da_valid && any_match) ? pick_idx : '0;
    end
  end
endmodule

// File: rtl/addr_match_filter_chk.sv
module addr_match_filter_chk #(
  parameter int NUM_PAIRS = 4,
  localparam int IDX_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
  localparam int SEL_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [SEL_W-1:0] wr_sel,
  input logic             da_valid,
  input logic             hit_valid,
  input logic             hit,
  input logic [IDX_W-1:0] hit_idx
);
  // Independent model of pair enables, taken from the write port only
  logic [NUM_PAIRS-1:0] sh_en, prev_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_en   <= '0;
      prev_en <= '0;
    end else begin
      prev_en <= sh_en;
      if (wr_en) sh_en[wr_sel[SEL_W-1:1]] <= wr_sel[0];
    end
  end

  // R1: outputs clear in the cycle after reset
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!hit_valid && !hit && hit_idx == '0));

  // R2: strobe gives a result one cycle later
  p_valid_follows_r2: assert property (@(posedge clk) disable iff (rst)
    da_valid |=> hit_valid);

  // R2: no result without a strobe
  p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (rst)
    !da_valid |=> !hit_valid);

  // R2: hit only together with a result
  p_hit_in_valid_r2: assert property (@(posedge clk) disable iff (rst)
    hit |-> hit_valid);

  // R4 / R5: a reported pair was enabled when the strobe was compared
  p_hit_enabled_r4: assert property (@(posedge clk) disable iff (rst)
    hit |-> prev_en[hit_idx]);

  // R8: index is zero when there is no hit
  p_idx_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !hit |-> hit_idx == '0);
endmodule

bind addr_match_filter addr_match_filter_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (.*);

// File: tb/addr_match_filter_bench.sv
module addr_match_filter_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        da_valid = 1'b0;
  logic [47:0] da = '0;
  logic        hit_valid, hit;
  logic [1:0]  hit_idx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [47:0] ADDR_A = 48'h5A3C_1234_9ABC;
  localparam logic [47:0] ADDR_B = 48'h0102_0304_0506;

  always #(CLK_P/2) clk = ~clk;

  addr_match_filter u_addr_match_filter (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic program_pair(input int p, input logic [47:0] a, input logic [15:0] junk);
    reg_write({p[1:0], 1'b0}, a[31:0]);
    reg_write({p[1:0], 1'b1}, {junk, a[47:32]});
  endtask

  // Strobe one address; outputs sampled at the following falling edge
  task automatic strobe(input logic [47:0] a, output logic v, output logic h, output logic [1:0] i);
    @(negedge clk);
    da_valid = 1'b1; da = a;
    @(negedge clk);
    da_valid = 1'b0;
    v = hit_valid; h = hit; i = hit_idx;
  endtask

  task automatic t_reset;
    logic v, h; logic [1:0] i;
    chk("R1 hit_valid", {31'd0, hit_valid}, 0);
    chk("R1 hit", {31'd0, hit}, 0);
    chk("R1 hit_idx", {30'd0, hit_idx}, 0);
    strobe(48'h0, v, h, i);
    chk("R1 addr0 no hit", {31'd0, h}, 0);
  endtask

  task automatic t_basic_match;
    logic v, h; logic [1:0] i;
    program_pair(2, ADDR_A, 16'hABCD);
    strobe(ADDR_A, v, h, i);
    chk("R2 valid", {31'd0, v}, 1);
    chk("R3 hit", {31'd0, h}, 1);
    chk("R3 idx", {30'd0, i}, 2);
    @(negedge clk);
    chk("R2 valid single", {31'd0, hit_valid}, 0);
    chk("R8 idle idx", {30'd0, hit_idx}, 0);
    strobe(ADDR_B, v, h, i);
    chk("R8 miss hit", {31'd0, h}, 0);
    chk("R8 miss idx", {30'd0, i}, 0);
    chk("R2 miss valid", {31'd0, v}, 1);
  endtask

  task automatic t_single_bit;
    logic v, h; logic [1:0] i;
    int bits[4] = '{0, 31, 32, 47};
    foreach (bits[n]) begin
      strobe(ADDR_A ^ (48'd1 << bits[n]), v, h, i);
      chk($sformatf("R9 bit %0d", bits[n]), {31'd0, h}, 0);
    end
  endtask

  task automatic t_priority;
    logic v, h; logic [1:0] i;
    program_pair(0, ADDR_B, 16'h0);
    program_pair(3, ADDR_A, 16'hFFFF);
    program_pair(1, ADDR_A, 16'h1111);
    strobe(ADDR_A, v, h, i);
    chk("R6 lowest idx", {30'd0, i}, 1);
    strobe(ADDR_B, v, h, i);
    chk("R6 pair0", {30'd0, i}, 0);
  endtask

  task automatic t_write_order;
    logic v, h; logic [1:0] i;
    reg_write(3'b010, ADDR_A[31:0]);        // low word of pair 1
    strobe(ADDR_A, v, h, i);
    chk("R4 disabled idx", {30'd0, i}, 2);
    reg_write(3'b000, ADDR_B[31:0]);        // low word of pair 0
    strobe(ADDR_B, v, h, i);
    chk("R4 pair0 off", {31'd0, h}, 0);
    reg_write(3'b011, {16'h0, ADDR_A[47:32]});
    strobe(ADDR_A, v, h, i);
    chk("R5 reenabled idx", {30'd0, i}, 1);
  endtask

  task automatic t_same_cycle;
    logic [1:0] i;
    // low-word write to pair 1 together with a strobe
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'b010; wr_data = ADDR_A[31:0];
    da_valid = 1'b1; da = ADDR_A;
    @(negedge clk);
    wr_en = 1'b0; da_valid = 1'b0;
    i = hit_idx;
    chk("R7 pre-write state", {30'd0, i}, 1);
    begin
      logic v, h;
      strobe(ADDR_A, v, h, i);
      chk("R7 after write", {30'd0, i}, 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic_match();
    t_single_bit();
    t_priority();
    t_write_order();
    t_same_cycle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule